// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Fetcher

This block is the descriptor-fetch front end of a single DMA channel. Descriptors sit back to back in memory as a circular ring. Each descriptor is 16 bytes, made of four 32-bit words. Software sets the ring's start address and its entry count. It then hands work to the engine by moving a tail pointer to the byte address just past the last descriptor it has prepared.

The engine keeps its own current-descriptor pointer and fetches one descriptor at a time through a simple one-outstanding-read memory port. It offers each assembled descriptor, together with its address, on a valid/ready output. The pointer moves on, wrapping at the end of the ring, only after the consumer takes the descriptor. When the pointer catches up with the tail, the engine suspends. It wakes as soon as software moves the tail again.

A run bit gates the whole engine. The current pointer and a three-state status code are visible at ports so that software can read them.

Top module: `ring_desc_fetch`

## Requirements
- R1: After reset the status is 0 (stopped), the current pointer is 0, and neither `rd_req` nor `desc_valid` is asserted.
- R2: A descriptor is read as four single-word reads at pointer+0, +4, +8 and +12. Only one read is in flight at a time, and `rd_addr` is held until `rd_valid` returns. Word k lands in `desc_data[32k+31:32k]`.
- R3: While running, the engine hands out, in ring order, every descriptor from the current pointer up to the one just below the tail. Each descriptor is presented with its own byte address on `desc_addr`.
- R4: While running with the current pointer equal to the tail, the status is 2 (suspended) and no reads are issued.
- R5: A tail write that makes the tail differ from the current pointer ends suspension, and fetching restarts.
- R6: The ring-length register (register 1) holds entries minus one. After the descriptor at base + 16 × length is accepted, the pointer returns to base.
- R7: Writing the base (register 0) or the ring length while stopped sets the current pointer to the base. Either write while running leaves the pointer unchanged.
- R8: The run bit is bit 0 of register 3. Clearing it lets a descriptor already in progress finish and be accepted, then the engine stops with status 0 and starts no new reads even if the tail differs. Setting it starts fetching.
- R9: The current pointer changes, while running, only on an accepted descriptor. While `desc_ready` is low, `desc_valid`, `desc_data` and `desc_addr` stay stable, and the status is 1 (fetching).
- R10: `cur_ptr` always shows the current descriptor pointer. The tail register is register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 base, 1 length-1, 2 tail, 3 control |
| reg_wdata | input | AW | Register write data |
| rd_req | output | 1 | Memory read request, held until response |
| rd_addr | output | AW | Read byte address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 32 | Read response word |
| desc_valid | output | 1 | Descriptor available |
| desc_data | output | 128 | Assembled descriptor, word 0 lowest |
| desc_addr | output | AW | Address of the offered descriptor |
| desc_ready | input | 1 | Consumer accepts descriptor |
| cur_ptr | output | AW | Current descriptor pointer |
| status | output | 2 | 0 stopped, 1 fetching, 2 suspended |

## Verification
A register write is taken at the next rising edge. Base, length and tail take effect, and `cur_ptr` shows any reset, from the following half cycle. A tail write that ends suspension raises `rd_req` one edge after the write edge. Each word then costs the memory latency plus one edge. `desc_valid` rises at the edge that takes the fourth word, and the pointer and status move at the accepting edge. The bench drives its inputs on falling edges and samples mid-cycle. It waits with bounded polling for acceptance counts or status codes rather than fixed delays, then compares pointer, addresses, words and read counts against values computed from the ring geometry.

// File: rtl/ring_desc_fetch.sv
module ring_desc_fetch #(
  parameter int AW = 32,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          desc_valid,
  output logic [127:0]  desc_data,
  output logic [AW-1:0] desc_addr,
  input  logic          desc_ready,
  output logic [AW-1:0] cur_ptr,
  output logic [1:0]    status
);
  localparam int NW     = 4;
  localparam int WIW    = $clog2(NW);
  localparam int STRIDE = NW * 4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_HOLD, S_SUSP} st_t;

  st_t                 st;
  logic [AW-1:0]       base_q, tail_q, cur_q;
  logic [LW-1:0]       len_q;
  logic                run_q;
  logic [WIW-1:0]      widx;
  logic [NW-1:0][31:0] words_q;

  wire wr_base = reg_we && reg_addr == 2'd0;
  wire wr_len  = reg_we && reg_addr == 2'd1;
  wire wr_tail = reg_we && reg_addr == 2'd2;
  wire wr_ctl  = reg_we && reg_addr == 2'd3;

  wire [AW-1:0] last_addr = base_q + (AW'(len_q) << 4);
  wire [AW-1:0] next_ptr  = (cur_q == last_addr) ? base_q : cur_q + AW'(STRIDE);

  assign rd_req     = st == S_FETCH;
  assign rd_addr    = cur_q + (AW'(widx) << 2);
  assign desc_valid = st == S_HOLD;
  assign desc_data  = words_q;
  assign desc_addr  = cur_q;
  assign cur_ptr    = cur_q;
  assign status     = (st == S_IDLE) ? 2'd0 : (st == S_SUSP) ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      tail_q  <= '0;
      cur_q   <= '0;
      len_q   <= '0;
      run_q   <= 1'b0;
      widx    <= '0;
      words_q <= '0;
    end else begin
      if (wr_base) base_q <= reg_wdata;
      if (wr_len)  len_q  <= reg_wdata[LW-1:0];
      if (wr_tail) tail_q <= reg_wdata;
      if (wr_ctl)  run_q  <= reg_wdata[0];
      unique case (st)
        S_IDLE: begin
          widx <= '0;
          if (wr_base)     cur_q <= reg_wdata;
          else if (wr_len) cur_q <= base_q;
          else if (run_q)  st    <= (cur_q == tail_q) ? S_SUSP : S_FETCH;
        end
        S_SUSP: begin
          widx <= '0;
          if (!run_q)               st <= S_IDLE;
          else if (cur_q != tail_q) st <= S_FETCH;
        end
        S_FETCH: begin
          if (rd_valid) begin
            words_q[widx] <= rd_data;
            widx          <= widx + 1'b1;
            if (widx == WIW'(NW - 1)) st <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (desc_ready) begin
            cur_q <= next_ptr;
            widx  <= '0;
            if (!run_q)                 st <= S_IDLE;
            else if (next_ptr == tail_q) st <= S_SUSP;
            else                        st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ring_desc_fetch_chk #(
  parameter int AW = 32,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          desc_valid,
  input logic [127:0]  desc_data,
  input logic [AW-1:0] desc_addr,
  input logic          desc_ready,
  input logic [AW-1:0] cur_ptr,
  input logic [1:0]    status,
  input logic [AW-1:0] base_q,
  input logic [LW-1:0] len_q
);
  a_r4_no_read_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd2 |-> !rd_req);
  a_r8_no_read_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd0 |-> !rd_req);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  a_r2_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && desc_valid));
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_data) && $stable(desc_addr));
  a_r9_ptr_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd0 && !(desc_valid && desc_ready) |=> $stable(cur_ptr));
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && desc_addr == base_q + (AW'(len_q) << 4)
    |=> cur_ptr == $past(base_q));
endmodule

bind ring_desc_fetch ring_desc_fetch_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .desc_valid(desc_valid), .desc_data(desc_data), .desc_addr(desc_addr),
  .desc_ready(desc_ready), .cur_ptr(cur_ptr), .status(status),
  .base_q(base_q), .len_q(len_q)
);

// File: tb/tb_ring_desc_fetch.sv
`timescale 1ns/1ps
module tb_ring_desc_fetch;
  logic         clk = 0, rst_n = 0;
  logic         reg_we = 0;
  logic [1:0]   reg_addr = 0;
  logic [31:0]  reg_wdata = 0;
  logic         rd_req, rd_valid = 0;
  logic [31:0]  rd_addr, rd_data = 0;
  logic         desc_valid, desc_ready = 1;
  logic [127:0] desc_data;
  logic [31:0]  desc_addr, cur_ptr;
  logic [1:0]   status;

  int n_chk = 0, n_bad = 0, n_acc = 0, rd_cnt = 0;
  bit done = 0;
  logic [31:0]  acc_addr [0:63];
  logic [127:0] acc_data [0:63];

  always #2.5 clk = ~clk;

  ring_desc_fetch dut (.*);

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction
  function automatic logic [127:0] expd(input logic [31:0] a);
    return {memf(a + 12), memf(a + 8), memf(a + 4), memf(a)};
  endfunction

  initial forever begin
    @(negedge clk);
    if (rd_valid) rd_valid = 0;
    else if (rd_req) begin
      rd_valid = 1;
      rd_data  = memf(rd_addr);
      rd_cnt++;
    end
  end

  initial forever begin
    @(negedge clk); #1;
    if (desc_valid && desc_ready && n_acc < 64) begin
      acc_addr[n_acc] = desc_addr;
      acc_data[n_acc] = desc_data;
      n_acc++;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wait_acc(input int target);
    for (int i = 0; i < 400 && n_acc < target; i++) @(negedge clk);
  endtask

  task automatic wait_stat(input logic [1:0] s);
    for (int i = 0; i < 400 && status !== s; i++) @(negedge clk);
  endtask

  task automatic chk_desc(input string tag, input int idx, input logic [31:0] a);
    chk({tag, " addr"}, acc_addr[idx], a);
    chk({tag, " data"}, acc_data[idx], expd(a));
  endtask

  task automatic t_reset;
    chk("R1 status", status, 0);
    chk("R1 cur", cur_ptr, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 desc_valid", desc_valid, 0);
  endtask

  task automatic t_setup_suspend;
    int r0;
    wr(0, 32'h1000);
    chk("R7 base write while stopped", cur_ptr, 32'h1000);
    wr(1, 3);
    wr(2, 32'h1000);
    wr(3, 1);
    repeat (3) @(negedge clk);
    chk("R4 status suspended", status, 2);
    r0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R4 no reads", rd_cnt - r0, 0);
  endtask

  task automatic t_two_desc;
    int n0 = n_acc, r0 = rd_cnt;
    wr(2, 32'h1020);
    wait_acc(n0 + 2);
    wait_stat(2);
    chk("R5 two accepted", n_acc - n0, 2);
    chk_desc("R3 first", n0, 32'h1000);
    chk_desc("R2 second", n0 + 1, 32'h1010);
    chk("R2 read count", rd_cnt - r0, 8);
    chk("R10 cur after", cur_ptr, 32'h1020);
    chk("R4 resuspend", status, 2);
  endtask

  task automatic t_wrap;
    int n0 = n_acc;
    wr(2, 32'h1000);
    wait_acc(n0 + 2);
    wait_stat(2);
    chk_desc("R6 entry2", n0, 32'h1020);
    chk_desc("R6 last", n0 + 1, 32'h1030);
    chk("R6 wrapped cur", cur_ptr, 32'h1000);
  endtask

  task automatic t_backpressure;
    int n0 = n_acc;
    logic [127:0] snap;
    @(negedge clk); desc_ready = 0;
    wr(2, 32'h1010);
    for (int i = 0; i < 400 && !desc_valid; i++) @(negedge clk);
    snap = desc_data;
    repeat (10) @(negedge clk);
    chk("R9 valid held", desc_valid, 1);
    chk("R9 data held", desc_data, snap);
    chk("R9 cur not advanced", cur_ptr, 32'h1000);
    chk("R9 status fetching", status, 1);
    desc_ready = 1;
    wait_acc(n0 + 1);
    wait_stat(2);
    chk_desc("R9 accepted", n0, 32'h1000);
    chk("R9 cur advanced", cur_ptr, 32'h1010);
  endtask

  task automatic t_stop;
    int n0 = n_acc, r0;
    @(negedge clk); desc_ready = 0;
    wr(2, 32'h1000);
    for (int i = 0; i < 400 && !desc_valid; i++) @(negedge clk);
    wr(3, 0);
    desc_ready = 1;
    wait_stat(0);
    repeat (2) @(negedge clk);
    chk("R8 one finished", n_acc - n0, 1);
    chk_desc("R8 finished", n0, 32'h1010);
    chk("R8 stopped", status, 0);
    r0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R8 no reads stopped", rd_cnt - r0, 0);
    chk("R8 cur stopped", cur_ptr, 32'h1020);
    wr(1, 1);
    chk("R7 len write resets cur", cur_ptr, 32'h1000);
  endtask

  task automatic t_small_ring;
    int n0;
    wr(0, 32'h2000);
    chk("R7 new base", cur_ptr, 32'h2000);
    wr(2, 32'h2010);
    n0 = n_acc;
    wr(3, 1);
    wait_acc(n0 + 1);
    wait_stat(2);
    chk_desc("R8 restart", n0, 32'h2000);
    wr(2, 32'h2000);
    wait_acc(n0 + 2);
    wait_stat(2);
    chk_desc("R6 small ring", n0 + 1, 32'h2010);
    chk("R6 small wrap", cur_ptr, 32'h2000);
    wr(0, 32'h3000);
    wr(1, 5);
    chk("R7 running base keeps cur", cur_ptr, 32'h2000);
    chk("R7 still suspended", status, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_setup_suspend;
    t_two_desc;
    t_wrap;
    t_backpressure;
    t_stop;
    t_small_ring;
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule